// File: doc/BRIEF.md
# Dual-processor handshake link

This block joins two processor-side port interfaces, a control side and an auxiliary side, so that either one can send a 7-bit word to the other. A side starts an exchange with a one-cycle kick command. The link then drives an active-low interrupt pulse onto the other side's interrupt line, so the sender becomes the initiator of the exchange. The initiator raises its request, drives the shared word and waits for the receiver's acknowledge. The exchange closes when the initiator drops its request and the receiver then drops its acknowledge.

When both sides kick in the same cycle, the control side goes first. A kick from the non-initiating side during a busy exchange is held and served once the link is idle again. The control side also drives an ownership select, which picks the processor that may use a shared serial controller. That select moves only while no exchange is in progress.

Top module: `duo_msg_link`

## Requirements
- R1: During and after reset, both interrupt lines read 1, `link_req_o`, `link_ack_o`, both output enables and both received-word strobes read 0, and `own_sel_o` reads 0 (control side owns the controller).
- R2: A kick from side S, sampled while the link is idle, drives the other side's interrupt line low for exactly PULSE_LEN cycles (default 4), starting at the next clock edge. S's own interrupt line stays at 1 throughout.
- R3: If both sides kick at the same edge while idle, the control side becomes the initiator. The auxiliary exchange starts on the first idle edge after the control exchange ends.
- R4: A kick from the non-initiating side during an exchange is held pending and starts a new exchange on the first idle edge. A kick from the initiator during its own exchange is ignored.
- R5: After the pulse, `link_req_o` rises on the edge at which the initiator's request input is seen high. The initiator's output enable equals `link_req_o`, and the other side's output enable stays 0.
- R6: `link_ack_o` rises on the edge at which the receiver's acknowledge input is seen high while `link_req_o` is 1. On that edge the initiator's data input is latched onto the receiver's data output, and the receiver's strobe is 1 for exactly one cycle.
- R7: The exchange ends in a fixed order. `link_req_o` falls on the edge after the initiator drops its request, then `link_ack_o` falls on the edge after the receiver drops its acknowledge. Dropping the acknowledge before the request has no effect.
- R8: `own_sel_o` takes the value of `ctl_own_i` (0 = control, 1 = auxiliary) on edges where the link is idle, and holds its value during an exchange.
- R9: The two interrupt lines are never low together, and the two output enables are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctl_kick_i | input | 1 | Control side: start an exchange toward the auxiliary side |
| ctl_req_i | input | 1 | Control side request |
| ctl_ack_i | input | 1 | Control side acknowledge |
| ctl_data_i | input | DATA_W | Control side word to send |
| ctl_data_o | output | DATA_W | Last word latched by the link |
| ctl_data_oe_o | output | 1 | Control side drives the shared word |
| ctl_irq_n_o | output | 1 | Active-low interrupt into the control side |
| ctl_rx_stb_o | output | 1 | Control side received a word |
| ctl_own_i | input | 1 | Requested controller owner |
| aux_kick_i | input | 1 | Auxiliary side: start an exchange toward the control side |
| aux_req_i | input | 1 | Auxiliary side request |
| aux_ack_i | input | 1 | Auxiliary side acknowledge |
| aux_data_i | input | DATA_W | Auxiliary side word to send |
| aux_data_o | output | DATA_W | Last word latched by the link |
| aux_data_oe_o | output | 1 | Auxiliary side drives the shared word |
| aux_irq_n_o | output | 1 | Active-low interrupt into the auxiliary side |
| aux_rx_stb_o | output | 1 | Auxiliary side received a word |
| link_req_o | output | 1 | Request line of the link |
| link_ack_o | output | 1 | Acknowledge line of the link |
| own_sel_o | output | 1 | Serial controller owner (0 control, 1 auxiliary) |

## Verification
The bench targets simultaneous kicks, kicks during a busy exchange from either side, an acknowledge dropped before the request, and owner changes requested in mid-exchange. A design with the tie resolved the wrong way pulses the control line first. One that drops pending kicks leaves the second exchange unstarted, and one that honours a self-kick starts a phantom exchange. The bench also changes the initiator's data right after the acknowledge, so a design that passes data through instead of latching it shows the wrong word. Pulse length is counted cycle by cycle, which catches off-by-one timers, and owner changes made mid-exchange must not reach `own_sel_o` until the link is idle again.

// File: rtl/duo_link_pkg.sv
package duo_link_pkg;
  typedef enum logic {SIDE_CTL = 1'b0, SIDE_AUX = 1'b1} side_e;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PULSE = 3'd1,
    ST_REQ   = 3'd2,
    ST_ACK   = 3'd3,
    ST_REL   = 3'd4,
    ST_FIN   = 3'd5
  } link_st_e;
endpackage

// File: rtl/duo_kick_arb.sv
module duo_kick_arb
  import duo_link_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       idle_i,
  input  side_e      init_i,
  input  logic [1:0] kick_i,
  output logic       grant_vld_o,
  output side_e      grant_side_o
);
  logic [1:0] pend_q, pend_d, want, grant_oh, init_oh;

  always_comb begin
    want         = kick_i | pend_q;
    init_oh      = (init_i == SIDE_AUX) ? 2'b10 : 2'b01;
    grant_vld_o  = idle_i && (|want);
    grant_side_o = want[0] ? SIDE_CTL : SIDE_AUX;
    grant_oh     = want[0] ? 2'b01 : 2'b10;
    if (idle_i) pend_d = grant_vld_o ? (want & ~grant_oh) : 2'b00;
    else        pend_d = pend_q | (kick_i & ~init_oh);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 2'b00;
    else         pend_q <= pend_d;
  end

  assert_no_self_pend_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle_i |-> ((pend_q & init_oh) == 2'b00));
endmodule

// File: rtl/duo_pulse_timer.sv
module duo_pulse_timer #(
  parameter int PULSE_LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic last_o
);
  localparam int CW = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(PULSE_LEN - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    last_o = (cnt_q == LAST);
    cnt_d  = cnt_q;
    if (clr_i)     cnt_d = '0;
    else if (en_i) cnt_d = last_o ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assert_cnt_in_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/duo_owner_sel.sv
module duo_owner_sel (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic idle_i,
  input  logic own_req_i,
  output logic sel_o
);
  logic sel_d;

  always_comb sel_d = idle_i ? own_req_i : sel_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_o <= 1'b0;
    else         sel_o <= sel_d;
  end

  assert_sel_held_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle_i |=> $stable(sel_o));
endmodule

// File: rtl/duo_msg_link.sv
module duo_msg_link
  import duo_link_pkg::*;
#(
  parameter int DATA_W    = 7,
  parameter int PULSE_LEN = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_kick_i,
  input  logic              ctl_req_i,
  input  logic              ctl_ack_i,
  input  logic [DATA_W-1:0] ctl_data_i,
  output logic [DATA_W-1:0] ctl_data_o,
  output logic              ctl_data_oe_o,
  output logic              ctl_irq_n_o,
  output logic              ctl_rx_stb_o,
  input  logic              ctl_own_i,
  input  logic              aux_kick_i,
  input  logic              aux_req_i,
  input  logic              aux_ack_i,
  input  logic [DATA_W-1:0] aux_data_i,
  output logic [DATA_W-1:0] aux_data_o,
  output logic              aux_data_oe_o,
  output logic              aux_irq_n_o,
  output logic              aux_rx_stb_o,
  output logic              link_req_o,
  output logic              link_ack_o,
  output logic              own_sel_o
);
  link_st_e          state_q, state_d;
  side_e             init_q, init_d, grant_side;
  logic              grant_vld, idle, tmr_clr, tmr_en, tmr_last;
  logic              req_init, ack_rx, word_en;
  logic [DATA_W-1:0] data_init, word_q;
  logic [1:0]        stb_q, stb_d;

  assign idle = (state_q == ST_IDLE);

  duo_kick_arb u_arb (
    .clk_i(clk_i), .rst_ni(rst_ni), .idle_i(idle), .init_i(init_q),
    .kick_i({aux_kick_i, ctl_kick_i}),
    .grant_vld_o(grant_vld), .grant_side_o(grant_side)
  );

  duo_pulse_timer #(.PULSE_LEN(PULSE_LEN)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(tmr_clr), .en_i(tmr_en),
    .last_o(tmr_last)
  );

  duo_owner_sel u_own (
    .clk_i(clk_i), .rst_ni(rst_ni), .idle_i(idle), .own_req_i(ctl_own_i),
    .sel_o(own_sel_o)
  );

  always_comb begin
    req_init  = (init_q == SIDE_AUX) ? aux_req_i  : ctl_req_i;
    ack_rx    = (init_q == SIDE_AUX) ? ctl_ack_i  : aux_ack_i;
    data_init = (init_q == SIDE_AUX) ? aux_data_i : ctl_data_i;
    state_d   = state_q;
    init_d    = init_q;
    word_en   = 1'b0;
    stb_d     = 2'b00;
    tmr_clr   = 1'b0;
    tmr_en    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        tmr_clr = 1'b1;
        if (grant_vld) begin
          state_d = ST_PULSE;
          init_d  = grant_side;
        end
      end
      ST_PULSE: begin
        tmr_en = 1'b1;
        if (tmr_last) state_d = ST_REQ;
      end
      ST_REQ: if (req_init) state_d = ST_ACK;
      ST_ACK: if (ack_rx) begin
        state_d = ST_REL;
        word_en = 1'b1;
        stb_d   = (init_q == SIDE_AUX) ? 2'b01 : 2'b10;
      end
      ST_REL:  if (!req_init) state_d = ST_FIN;
      ST_FIN:  if (!ack_rx)   state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      init_q  <= SIDE_CTL;
      stb_q   <= 2'b00;
    end else begin
      state_q <= state_d;
      init_q  <= init_d;
      stb_q   <= stb_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      word_q <= '0;
    else if (word_en) word_q <= data_init;
  end

  always_comb begin
    aux_irq_n_o   = !((state_q == ST_PULSE) && (init_q == SIDE_CTL));
    ctl_irq_n_o   = !((state_q == ST_PULSE) && (init_q == SIDE_AUX));
    link_req_o    = (state_q == ST_ACK) || (state_q == ST_REL);
    link_ack_o    = (state_q == ST_REL) || (state_q == ST_FIN);
    ctl_data_oe_o = link_req_o && (init_q == SIDE_CTL);
    aux_data_oe_o = link_req_o && (init_q == SIDE_AUX);
    ctl_data_o    = word_q;
    aux_data_o    = word_q;
    ctl_rx_stb_o  = stb_q[0];
    aux_rx_stb_o  = stb_q[1];
  end

  assert_irq_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_irq_n_o || aux_irq_n_o);
  assert_oe_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctl_data_oe_o && aux_data_oe_o));
  assert_req_follows_init_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(link_req_o) |-> $past(req_init));
  assert_stb_on_ack_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(link_ack_o) |-> $onehot(stb_q));
  assert_stb_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|stb_q) |=> (stb_q == 2'b00));
  assert_ack_falls_last_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(link_ack_o) |-> !link_req_o);
endmodule

// File: tb/duo_msg_link_tb.sv
`timescale 1ns/1ps
module duo_msg_link_tb;
  localparam int W = 7;
  localparam int L = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rst_n;
  logic [1:0]   kick, req, ack;
  logic [W-1:0] din0, din1;
  logic         own;
  logic [W-1:0] dout0, dout1;
  logic [1:0]   oe, irq_n, stb;
  logic         lreq, lack, sel;

  duo_msg_link #(.DATA_W(W), .PULSE_LEN(L)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .ctl_kick_i(kick[0]), .ctl_req_i(req[0]), .ctl_ack_i(ack[0]),
    .ctl_data_i(din0), .ctl_data_o(dout0), .ctl_data_oe_o(oe[0]),
    .ctl_irq_n_o(irq_n[0]), .ctl_rx_stb_o(stb[0]), .ctl_own_i(own),
    .aux_kick_i(kick[1]), .aux_req_i(req[1]), .aux_ack_i(ack[1]),
    .aux_data_i(din1), .aux_data_o(dout1), .aux_data_oe_o(oe[1]),
    .aux_irq_n_o(irq_n[1]), .aux_rx_stb_o(stb[1]),
    .link_req_o(lreq), .link_ack_o(lack), .own_sel_o(sel)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic exp_sel;

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic logic [W-1:0] rx_word(input bit s);
    return s ? dout1 : dout0;
  endfunction

  function automatic bit exp_oe(input bit side, input bit init, input bit active);
    return active && (side == init);
  endfunction

  task automatic set_data(input bit s, input logic [W-1:0] w);
    if (s) din1 = w; else din0 = w;
  endtask

  task automatic wiggle_own();
    own = 1'($urandom % 2);
  endtask

  // Called at the negedge where the peer pulse is first visible.
  task automatic pulse_and_xfer(input bit s, input logic [W-1:0] w, input int g,
                                input bit kick_other, input bit kick_self);
    bit r = ~s;
    for (int i = 0; i < L; i++) begin
      chk(irq_n[r] == 1'b0, "R2 peer irq low", irq_n[r], 0);
      chk(irq_n[s] == 1'b1, "R2 own irq high", irq_n[s], 1);
      chk(sel == exp_sel, "R8 sel held in pulse", sel, exp_sel);
      wiggle_own();
      tick();
    end
    chk(irq_n[r] == 1'b1, "R2 pulse ended", irq_n[r], 1);
    for (int i = 0; i < g; i++) begin
      chk(lreq == 1'b0, "R5 no req yet", lreq, 0);
      chk(oe == 2'b00, "R5 oe idle", oe, 0);
      wiggle_own();
      tick();
    end
    req[s] = 1'b1;
    set_data(s, w);
    tick();
    chk(lreq == 1'b1, "R5 link req", lreq, 1);
    chk(oe[s] == exp_oe(s, s, 1'b1), "R5 initiator oe", oe[s], 1);
    chk(oe[r] == exp_oe(r, s, 1'b1), "R5 other oe", oe[r], 0);
    chk(sel == exp_sel, "R8 sel held in xfer", sel, exp_sel);
    for (int i = 0; i < g; i++) begin
      chk(lack == 1'b0, "R6 no ack yet", lack, 0);
      chk(stb == 2'b00, "R6 no strobe yet", stb, 0);
      wiggle_own();
      tick();
    end
    if (kick_other || kick_self) begin
      kick[r] = kick_other;
      kick[s] = kick_self;
      tick();
      kick = 2'b00;
    end
    ack[r] = 1'b1;
    tick();
    chk(lack == 1'b1, "R6 link ack", lack, 1);
    chk(stb[r] == 1'b1, "R6 receiver strobe", stb[r], 1);
    chk(stb[s] == 1'b0, "R6 sender no strobe", stb[s], 0);
    chk(rx_word(r) == w, "R6 word latched", rx_word(r), w);
    set_data(s, ~w);
    tick();
    chk(stb == 2'b00, "R6 strobe one cycle", stb, 0);
    chk(rx_word(r) == w, "R6 word held", rx_word(r), w);
    ack[r] = 1'b0;
    tick();
    chk(lack == 1'b1, "R7 early ack drop ignored", lack, 1);
    chk(lreq == 1'b1, "R7 req still up", lreq, 1);
    ack[r] = 1'b1;
    req[s] = 1'b0;
    tick();
    chk(lreq == 1'b0, "R7 req fell", lreq, 0);
    chk(oe == 2'b00, "R5 oe released", oe, 0);
    chk(lack == 1'b1, "R7 ack still up", lack, 1);
    ack[r] = 1'b0;
    own = exp_sel;
    tick();
    chk(lack == 1'b0, "R7 ack fell", lack, 0);
    chk(irq_n == 2'b11, "R2 irqs idle", irq_n, 3);
  endtask

  task automatic kick_side(input bit s);
    kick[s] = 1'b1;
    tick();
    kick = 2'b00;
  endtask

  task automatic idle_sel(input logic v);
    own = v;
    tick();
    exp_sel = v;
    chk(sel == exp_sel, "R8 sel follows when idle", sel, exp_sel);
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5EED_0A7);
    rst_n = 1'b0; kick = '0; req = '0; ack = '0;
    din0 = '0; din1 = '0; own = 1'b0; exp_sel = 1'b0;
    repeat (3) tick();
    chk(irq_n == 2'b11, "R1 irq in reset", irq_n, 3);
    chk({lreq, lack} == 2'b00, "R1 lines in reset", {lreq, lack}, 0);
    chk(oe == 2'b00 && stb == 2'b00, "R1 oe/stb in reset", {oe, stb}, 0);
    chk(sel == 1'b0, "R1 sel in reset", sel, 0);
    rst_n = 1'b1;
    tick();
    chk(irq_n == 2'b11, "R1 irq after reset", irq_n, 3);
    chk(sel == 1'b0, "R1 sel after reset", sel, 0);

    // Directed: plain exchanges both ways
    kick_side(1'b0);
    pulse_and_xfer(1'b0, 7'h55, 1, 1'b0, 1'b0);
    kick_side(1'b1);
    pulse_and_xfer(1'b1, 7'h2A, 0, 1'b0, 1'b0);

    // R3: tie goes to control, aux follows
    kick = 2'b11;
    tick();
    kick = 2'b00;
    chk(irq_n[1] == 1'b0 && irq_n[0] == 1'b1, "R3 control wins tie", irq_n, 1);
    pulse_and_xfer(1'b0, 7'h7F, 0, 1'b0, 1'b0);
    tick();
    chk(irq_n[0] == 1'b0, "R3 aux served after", irq_n[0], 0);
    pulse_and_xfer(1'b1, 7'h01, 0, 1'b0, 1'b0);

    // R4: self kick ignored
    kick_side(1'b1);
    pulse_and_xfer(1'b1, 7'h33, 1, 1'b0, 1'b1);
    for (int i = 0; i < 6; i++) begin
      tick();
      chk(irq_n == 2'b11 && !lreq, "R4 self kick ignored", irq_n, 3);
    end
    // R4: other side's kick held pending
    kick_side(1'b1);
    pulse_and_xfer(1'b1, 7'h4C, 2, 1'b1, 1'b0);
    tick();
    chk(irq_n[1] == 1'b0, "R4 pending kick served", irq_n[1], 0);
    pulse_and_xfer(1'b0, 7'h12, 1, 1'b0, 1'b0);

    // R8: owner moves while idle
    idle_sel(1'b1);
    idle_sel(1'b0);
    idle_sel(1'b1);

    // Random mix
    for (int it = 0; it < 30; it++) begin
      bit s = 1'($urandom % 2);
      bit ko = (($urandom % 4) == 0);
      idle_sel(1'($urandom % 2));
      kick_side(s);
      pulse_and_xfer(s, 7'($urandom), int'($urandom % 4), ko, 1'b0);
      if (ko) begin
        tick();
        pulse_and_xfer(~s, 7'($urandom), int'($urandom % 3), 1'b0, 1'b0);
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule